// File: doc/BRIEF.md
# Clocked Serial Byte Transmitter

This block sends one byte at a time over a two-wire synchronous link: a transfer clock and a serial data line going to an external receiver. A single write strobe loads the byte, and that write also starts the transfer. No separate start command exists. While the link is idle, the transfer clock rests high and the data line is released. The released state is modelled as an output-enable signal that is low.

The shift clock comes from an internal divider. First one of three prescaled versions of the system clock is picked (divide by 1, 8 or 32). An 8-bit rate value `n` then stretches each half period of the transfer clock to `n+1` prescaled ticks. The full transfer-clock period is therefore `2*(n+1)*div` system cycles. Data changes on falling edges only, so the receiver can sample on rising edges. After the eighth rising edge a sticky interrupt flag is set. It stays set until a software clear strobe or an acknowledge strobe drops it.

The prescaler choice, the rate value and the bit order are captured at the accepted write. A write that arrives while a byte is in flight is refused and leaves that byte untouched.

Top module: `sio_byte_tx`

## Requirements
- R1: While reset is asserted and right after it, `tx_clk_o` is 1 and `tx_dat_oe`, `busy` and `irq_flag` are 0.
- R2: A write (`wr_en`=1) sampled while `busy` is 0 is accepted and `busy` is 1 from the next cycle. The first falling edge of `tx_clk_o` comes `(n+1)*div` cycles after the accepting edge, which is half a transfer-clock period and so within 1.5 periods.
- R3: The half period of `tx_clk_o` is `(n+1)*div` system cycles, with `n` = `cfg_rate`. `cfg_src` selects `div`: 2'b00 gives 1, 2'b01 gives 8, 2'b10 and 2'b11 give 32.
- R4: Exactly eight falling edges occur per byte. `tx_dat_o` takes a new bit only on a falling edge and holds it until the next falling edge or the end of the transfer.
- R5: With `cfg_msb_first`=0 the bits go out as `wr_data[0]` first through `wr_data[7]`. With `cfg_msb_first`=1 they go out as `wr_data[7]` first down to `wr_data[0]`.
- R6: `irq_flag` goes to 1 on the same edge as the eighth rising edge of `tx_clk_o`. It stays at 1 until a cycle in which `irq_clr` or `irq_ack` is 1, and goes to 0 after that cycle.
- R7: After the eighth rising edge, the last bit stays driven for one further half period. Then `tx_dat_oe` and `busy` both drop on the same edge, and `tx_clk_o` stays at 1 while idle.
- R8: A write sampled while `busy` is 1 is ignored: the byte in flight, its timing and its end are unchanged.
- R9: `cfg_src`, `cfg_rate` and `cfg_msb_first` are captured at the accepted write. Changing them during a transfer has no effect on that transfer.
- R10: A write and an `irq_clr` in the same idle cycle are both honoured: the flag drops, the transfer starts, and its completion sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_src | input | 2 | Prescaler select (00 /1, 01 /8, 10 or 11 /32) |
| cfg_msb_first | input | 1 | 1 sends bit 7 first, 0 sends bit 0 first |
| cfg_rate | input | 8 | Rate value n; half period is n+1 prescaled ticks |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| irq_ack | input | 1 | Acknowledge clear of the interrupt flag |
| tx_clk_o | output | 1 | Transfer clock, idles high |
| tx_dat_o | output | 1 | Serial data value |
| tx_dat_oe | output | 1 | Data output enable, 0 means high-impedance |
| busy | output | 1 | High from the accepted write until the output is released |
| irq_flag | output | 1 | Sticky end-of-byte interrupt request |

## Verification
The bench checks the divide arithmetic at the shortest setting (n=0 with divide by 1) and at each prescaler code. At those settings, an off-by-one in the tick counter or in the prescaler terminal count moves every clock edge and the first-edge latency. Its checks are made cycle by cycle from a model of the edge schedule. A mid-transfer write with different data and changed configuration is injected. A design that restarts, reloads the shifter or reads the live configuration would then send wrong bits or wrong timing. The bench also watches the half-period hold after the last bit, where an early release or a missing tail would shift the `tx_dat_oe` fall. It covers the cycle in which a write meets a flag clear, where a design that drops either event would leave the flag set or never start.

// File: rtl/sio_tx_pkg.sv
// Shared types and helpers for the clocked serial byte transmitter.
// Assumes a prescaler no wider than PRE_W bits (largest divide is 32).
package sio_tx_pkg;

    // Prescaler source select codes, decoded by the rate generator
    typedef enum logic [1:0] {
        SRC_DIV1   = 2'b00,
        SRC_DIV8   = 2'b01,
        SRC_DIV32  = 2'b10,
        SRC_DIV32B = 2'b11
    } src_sel_e;

    localparam int PRE_W   = 5;
    localparam int EV_W    = 5;
    // Event index (0-based) of the eighth rising edge and of the release
    localparam logic [EV_W-1:0] EV_LAST_RISE = EV_W'(15);
    localparam logic [EV_W-1:0] EV_RELEASE   = EV_W'(16);

    // Terminal count of the prescaler for a given source
    function automatic logic [PRE_W-1:0] pre_last(input src_sel_e s);
        case (s)
            SRC_DIV1: pre_last = PRE_W'(0);
            SRC_DIV8: pre_last = PRE_W'(7);
            default:  pre_last = PRE_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/sio_rate_gen.sv
// Rate generator: produces a one-cycle half_tick every (rate+1)*div cycles
// while run is high. Both counters sit at zero when run is low, so the
// first tick after a start lands exactly one half period later.
// Assumes src and rate are stable while run is high.
module sio_rate_gen
    import sio_tx_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  src_sel_e          src,
    input  logic [RATE_W-1:0] rate,
    output logic              half_tick
);

    logic [PRE_W-1:0]  pre_q;
    logic [RATE_W-1:0] cnt_q;
    logic              pre_tick;

    assign pre_tick  = run && (pre_q == pre_last(src));
    assign half_tick = pre_tick && (cnt_q == rate);

    // Prescaler: counts system cycles up to the selected terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !run || pre_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Rate counter: counts prescaled ticks up to the rate value
    always_ff @(posedge clk) begin
        if (!rst_n || !run || half_tick) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sio_shift_core.sv
// Shift core: accepts a byte when idle, captures the configuration, and
// walks 17 half-period events: odd events are falling edges that drive
// the next bit, even events are rising edges, and the 17th releases the
// line. Assumes half_tick is only high while busy.
module sio_shift_core
    import sio_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  src_sel_e          cfg_src,
    input  logic              cfg_msb_first,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              half_tick,
    output src_sel_e          src_q,
    output logic [RATE_W-1:0] rate_q,
    output logic              busy_q,
    output logic              tx_clk_q,
    output logic              tx_dat_q,
    output logic              tx_oe_q,
    output logic              byte_done
);

    logic [DATA_W-1:0] sh_q;
    logic [EV_W-1:0]   ev_q;
    logic              msb_q;
    logic              accept;
    logic              step;

    assign accept    = wr_en && !busy_q;
    assign step      = busy_q && half_tick;
    assign byte_done = step && (ev_q == EV_LAST_RISE);

    // Configuration capture at the accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_DIV1;
            rate_q <= '0;
            msb_q  <= 1'b0;
        end else if (accept) begin
            src_q  <= cfg_src;
            rate_q <= cfg_rate;
            msb_q  <= cfg_msb_first;
        end
    end

    // Busy and event counter: start on accept, end on the release event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ev_q   <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            ev_q   <= '0;
        end else if (step) begin
            if (ev_q == EV_RELEASE) begin
                busy_q <= 1'b0;
                ev_q   <= '0;
            end else begin
                ev_q <= ev_q + 1'b1;
            end
        end
    end

    // Line drivers and shifter: clock edges, bit output and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_clk_q <= 1'b1;
            tx_oe_q  <= 1'b0;
            tx_dat_q <= 1'b0;
            sh_q     <= '0;
        end else if (accept) begin
            sh_q <= wr_data;
        end else if (step) begin
            if (ev_q == EV_RELEASE) begin
                tx_oe_q  <= 1'b0;
                tx_clk_q <= 1'b1;
            end else if (!ev_q[0]) begin
                tx_clk_q <= 1'b0;
                tx_oe_q  <= 1'b1;
                tx_dat_q <= msb_q ? sh_q[DATA_W-1] : sh_q[0];
                sh_q     <= msb_q ? {sh_q[DATA_W-2:0], 1'b0}
                                  : {1'b0, sh_q[DATA_W-1:1]};
            end else begin
                tx_clk_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_irq_flag.sv
// Sticky interrupt flag: set by the end-of-byte pulse, cleared by either
// clear strobe. A set in the same cycle as a clear wins.
module sio_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_byte_tx.sv
// Top of the clocked serial byte transmitter. Wires the shift core, the
// rate generator and the interrupt flag. A write when idle starts one
// byte; the data line is released between transfers.
module sio_byte_tx
    import sio_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_src,
    input  logic              cfg_msb_first,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              irq_ack,
    output logic              tx_clk_o,
    output logic              tx_dat_o,
    output logic              tx_dat_oe,
    output logic              busy,
    output logic              irq_flag
);

    src_sel_e          src_q;
    logic [RATE_W-1:0] rate_q;
    logic              half_tick;
    logic              byte_done;

    sio_shift_core #(
        .DATA_W (DATA_W),
        .RATE_W (RATE_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .cfg_src       (src_sel_e'(cfg_src)),
        .cfg_msb_first (cfg_msb_first),
        .cfg_rate      (cfg_rate),
        .half_tick     (half_tick),
        .src_q         (src_q),
        .rate_q        (rate_q),
        .busy_q        (busy),
        .tx_clk_q      (tx_clk_o),
        .tx_dat_q      (tx_dat_o),
        .tx_oe_q       (tx_dat_oe),
        .byte_done     (byte_done)
    );

    sio_rate_gen #(
        .RATE_W (RATE_W)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .src       (src_q),
        .rate      (rate_q),
        .half_tick (half_tick)
    );

    sio_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (byte_done),
        .clr    (irq_clr || irq_ack),
        .flag_q (irq_flag)
    );

endmodule

// File: rtl/sio_tx_chk.sv
// Checker for the serial byte transmitter, observing the top-level ports.
module sio_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic irq_clr,
    input logic irq_ack,
    input logic tx_clk_o,
    input logic tx_dat_o,
    input logic tx_dat_oe,
    input logic busy,
    input logic irq_flag
);

    // R2
    idle_write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> busy);

    // R7
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_dat_oe);

    // R7
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_clk_o);

    // R4
    dat_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dat_oe && $past(tx_dat_oe) && !$fell(tx_clk_o)) |-> $stable(tx_dat_o));

    // R6
    irq_set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($rose(tx_clk_o) && busy));

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr && !irq_ack) |=> irq_flag);

    // R7
    release_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_dat_oe) |-> $fell(busy));

endmodule

bind sio_byte_tx sio_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .irq_clr   (irq_clr),
    .irq_ack   (irq_ack),
    .tx_clk_o  (tx_clk_o),
    .tx_dat_o  (tx_dat_o),
    .tx_dat_oe (tx_dat_oe),
    .busy      (busy),
    .irq_flag  (irq_flag)
);

// File: tb/tb_sio_byte_tx.sv
// Bench for sio_byte_tx: directed corners plus seeded random transfers,
// each checked cycle by cycle against an edge-schedule model.
module tb_sio_byte_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       cfg_msb_first = 1'b0;
    logic [7:0] cfg_rate = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       tx_clk_o, tx_dat_o, tx_dat_oe, busy, irq_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sio_byte_tx dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_src       (cfg_src),
        .cfg_msb_first (cfg_msb_first),
        .cfg_rate      (cfg_rate),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .irq_clr       (irq_clr),
        .irq_ack       (irq_ack),
        .tx_clk_o      (tx_clk_o),
        .tx_dat_o      (tx_dat_o),
        .tx_dat_oe     (tx_dat_oe),
        .busy          (busy),
        .irq_flag      (irq_flag)
    );

    function automatic int div_of(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 8 : 32;
    endfunction

    // Expected transfer clock for half-period event e (R3, R7)
    function automatic logic exp_clk(input int e);
        return (e >= 1 && e <= 16) ? ((e % 2) == 0) : 1'b1;
    endfunction

    function automatic logic exp_oe(input int e);
        return (e >= 1 && e <= 16);
    endfunction

    // Expected data bit during event e (R5)
    function automatic logic exp_bit(input logic [7:0] d, input logic msb, input int e);
        int idx = (e - 1) / 2;
        return msb ? d[7 - idx] : d[idx];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One transfer; inj >= 0 injects a foreign write plus config change at
    // that cycle (R8, R9); clr_same pairs the write with a clear (R10)
    task automatic xfer(input logic [7:0] d, input logic [1:0] src, input logic msb,
                        input logic [7:0] n, input int inj, input bit clr_same);
        int  h = (int'(n) + 1) * div_of(src);
        logic prev_irq = irq_flag;
        string dtag = (inj >= 0) ? "R8/R9 data" : "R5 data";
        string ttag = (inj >= 0) ? "R9 clk" : "R3 clk";
        chk("R2 idle before write", busy, 1'b0);
        wr_en = 1'b1; wr_data = d; cfg_src = src; cfg_msb_first = msb; cfg_rate = n;
        irq_clr = clr_same;
        @(negedge clk);
        wr_en = 1'b0; irq_clr = 1'b0;
        for (int t = 0; t <= 17 * h; t++) begin
            int e = t / h;
            if (t > 0) @(negedge clk);
            chk(ttag, tx_clk_o, exp_clk(e));
            chk("R7 oe", tx_dat_oe, exp_oe(e));
            chk("R2 busy", busy, (e < 17));
            chk(clr_same ? "R10 irq" : "R6 irq", irq_flag,
                (e >= 16) ? 1'b1 : (clr_same ? 1'b0 : prev_irq));
            if (exp_oe(e)) chk(dtag, tx_dat_o, exp_bit(d, msb, e));
            if (t == inj) begin
                wr_en = 1'b1; wr_data = ~d; cfg_msb_first = ~msb;
                cfg_rate = n + 8'd3; cfg_src = src ^ 2'b01;
            end else if (t == inj + 1) begin
                wr_en = 1'b0;
            end
        end
    endtask

    // Check the flag holds, then clear it with one of the two strobes (R6)
    task automatic clear_irq(input bit use_ack);
        repeat (3) begin
            @(negedge clk);
            chk("R6 irq held", irq_flag, 1'b1);
        end
        if (use_ack) irq_ack = 1'b1; else irq_clr = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; irq_clr = 1'b0;
        chk("R6 irq cleared", irq_flag, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 clk in reset", tx_clk_o, 1'b1);
        chk("R1 oe in reset", tx_dat_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clk", tx_clk_o, 1'b1);
        chk("R1 oe", tx_dat_oe, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 irq", irq_flag, 1'b0);

        // Directed corners
        xfer(8'hA5, 2'b00, 1'b0, 8'd0, -1, 1'b0); clear_irq(1'b0);
        xfer(8'h3C, 2'b00, 1'b1, 8'd0, -1, 1'b0); clear_irq(1'b1);
        xfer(8'h81, 2'b01, 1'b0, 8'd2, -1, 1'b0); clear_irq(1'b0);
        xfer(8'h6E, 2'b10, 1'b1, 8'd1, -1, 1'b0); clear_irq(1'b1);
        xfer(8'hD2, 2'b11, 1'b0, 8'd0, -1, 1'b0);
        // R10: previous flag still set, write meets clear
        xfer(8'h17, 2'b00, 1'b1, 8'd3, -1, 1'b1); clear_irq(1'b0);
        // R8, R9: foreign write and config change mid-transfer
        xfer(8'hC9, 2'b00, 1'b0, 8'd4, 5 * 5 + 1, 1'b0); clear_irq(1'b1);
        xfer(8'h4B, 2'b01, 1'b1, 8'd1, 16 * 9 + 3, 1'b0); clear_irq(1'b0);

        // Seeded random transfers
        for (int i = 0; i < 12; i++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic [7:0] n = (s == 2'b00) ? 8'($urandom_range(0, 63))
                          : (s == 2'b01) ? 8'($urandom_range(0, 15))
                          : 8'($urandom_range(0, 3));
            int h = (int'(n) + 1) * div_of(s);
            int inj = ((i % 3) == 0) ? int'($urandom_range(0, 15 * h)) : -1;
            xfer(8'($urandom), s, 1'($urandom), n, inj, 1'b0);
            clear_irq(1'(i % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule